// File: doc/BRIEF.md
# Operand Readiness Scoreboard with Class-Pair Forwarding

This block keeps a small timing record for every integer and floating-point architectural register. When an instruction issues and writes a register, the record for that register is loaded from the producer's class and precision. A second, independent port presents a candidate instruction: its consumer class and up to three source operands, each with a valid bit, a register-file select and an index. The block answers, per operand and overall, whether the candidate can issue in the current cycle.

The time a consumer must wait is usually the producer's full result latency. Certain producer and consumer pairs have forwarding paths that shorten the wait. The shortened wait depends on both sides of the pair. For stores, only the data operand benefits; the address operand always waits the full latency. Readiness is judged from registered state only. A candidate examined in the same cycle as an issue sees the register state from before that issue.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every operand of every register in both files reports ready and `stall` is low.
- R2: Integer-side producer codes and full latencies in cycles (an operand issued in cycle t becomes ready in cycle t+L when no forwarding applies): 0 constant/NOP 1, 1 ALU 2, 2 short-forward-branch ALU 2, 3 integer load 3, 4 multiply 3, 5 integer divide 16, 6 jump/call 1.
- R3: FP-side producer codes and full latencies: 9 FP load 2; 10 FP add/multiply/fused multiply-add 5 when `iss_dbl`=0 and 7 when `iss_dbl`=1; 11 FP convert/compare/move 3; 12 FP divide/square root 27 when `iss_dbl`=0 and 56 when `iss_dbl`=1; 13 integer-to-FP move 3; 14 FP-to-integer move 3.
- R4: Consumer codes are 0 plain (no forwarding), 1 ALU, 2 branch, 3 short-forward-branch ALU, 4 store, 5 FP arithmetic/divide/square root; codes 6 and 7 act as plain. Producers 1, 2, 3, 4 and 14 are ready after 1 cycle to consumers 1 and 2.
- R5: Producers 1 and 2 are ready after 1 cycle to consumer 3; other producers give consumer 3 their full latency.
- R6: For a store consumer, operand slot 1 is store data and gets the same 1-cycle wait from producers 1, 2, 3, 4 and 14 (and 2 cycles from producer 11), while slot 0 and slot 2 are address operands and always wait the full latency.
- R7: Producers 11 and 13 are ready after 2 cycles to consumer 5.
- R8: Producer 11 is ready after 2 cycles to consumers 1 and 2 and to store data.
- R9: Integer register 0 always reports ready, and an issue that targets it leaves every register unchanged; FP register 0 is tracked like any other.
- R10: A newer issue to a register replaces the pending record, so readiness follows the latest writer only.
- R11: Producer codes 7 (store), 8 (branch) and 15 (reserved) write no register and change no readiness.
- R12: `src_rdy[i]` is high when slot i is invalid or its register is ready for the presented consumer; `stall` is high exactly when some valid slot is not ready; the integer and FP files are tracked separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_cls | input | 4 | Producer class code of the issuing instruction |
| iss_dbl | input | 1 | Double precision for FP arithmetic and divide classes |
| iss_fp | input | 1 | Destination is in the FP file |
| iss_dst | input | REG_W | Destination register index |
| cand_cls | input | 3 | Consumer class code of the candidate |
| cand_v | input | N_SRC | Per-slot source valid |
| cand_fp | input | N_SRC | Per-slot source is in the FP file |
| cand_idx | input | N_SRC*REG_W | Per-slot source index, slot i in bits [i*REG_W +: REG_W] |
| src_rdy | output | N_SRC | Per-slot ready |
| stall | output | 1 | Candidate must wait |

## Verification
A wrong record inside the block appears at the ports as a wrong `src_rdy` bit the next time a candidate names that register. A countdown loaded with the wrong value or decrementing at the wrong rate moves the first ready cycle by one or more cycles, and a probe on every cycle after issue exposes that within the producer's latency. A wrong forwarding choice shows as a slot ready one or two cycles early or late for one consumer class while other classes stay correct, so the probes cross producers with every consumer and both store slots. A lost or misdirected write shows as a register that stays ready when it should be busy, or a neighbouring register that goes busy.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam int MAX_LAT = 56;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [3:0] {
    P_CONST  = 4'd0,
    P_ALU    = 4'd1,
    P_SFB    = 4'd2,
    P_LOAD   = 4'd3,
    P_MUL    = 4'd4,
    P_DIV    = 4'd5,
    P_JUMP   = 4'd6,
    P_STORE  = 4'd7,
    P_BRANCH = 4'd8,
    P_FPLOAD = 4'd9,
    P_FMA    = 4'd10,
    P_FPMISC = 4'd11,
    P_FDIV   = 4'd12,
    P_I2F    = 4'd13,
    P_F2I    = 4'd14,
    P_RSVD   = 4'd15
  } prod_e;

  typedef enum logic [2:0] {
    C_PLAIN  = 3'd0,
    C_ALU    = 3'd1,
    C_BRANCH = 3'd2,
    C_SFB    = 3'd3,
    C_STORE  = 3'd4,
    C_FP     = 3'd5,
    C_RSV6   = 3'd6,
    C_RSV7   = 3'd7
  } cons_e;

  typedef struct packed {
    prod_e cls;
    logic  dbl;
  } tag_t;

  // A producer class that leaves a result in a register file.
  function automatic logic writes_dest(prod_e c);
    return !(c inside {P_STORE, P_BRANCH, P_RSVD});
  endfunction

  // Full result latency of a producer, in cycles.
  function automatic cnt_t full_lat(tag_t t);
    cnt_t l;
    case (t.cls)
      P_CONST, P_JUMP:                  l = cnt_t'(1);
      P_ALU, P_SFB, P_FPLOAD:           l = cnt_t'(2);
      P_LOAD, P_MUL, P_FPMISC,
      P_I2F, P_F2I:                     l = cnt_t'(3);
      P_DIV:                            l = cnt_t'(16);
      P_FMA:                            l = t.dbl ? cnt_t'(7) : cnt_t'(5);
      P_FDIV:                           l = t.dbl ? cnt_t'(56) : cnt_t'(27);
      default:                          l = cnt_t'(0);
    endcase
    return l;
  endfunction

  // Wait seen by one consumer slot, after forwarding is taken into account.
  function automatic cnt_t eff_lat(tag_t t, cons_e c, logic data_slot);
    logic fast_int;
    logic alu_src;
    logic int_use;
    logic st_data;
    cnt_t r;
    fast_int = t.cls inside {P_LOAD, P_ALU, P_MUL, P_F2I, P_SFB};
    alu_src  = t.cls inside {P_ALU, P_SFB};
    int_use  = (c == C_ALU) || (c == C_BRANCH);
    st_data  = (c == C_STORE) && data_slot;
    if (fast_int && (int_use || st_data))
      r = cnt_t'(1);
    else if (alu_src && (c == C_SFB))
      r = cnt_t'(1);
    else if ((t.cls == P_FPMISC) && (int_use || st_data || (c == C_FP)))
      r = cnt_t'(2);
    else if ((t.cls == P_I2F) && (c == C_FP))
      r = cnt_t'(2);
    else
      r = full_lat(t);
    return r;
  endfunction

  // Highest countdown value at which the consumer may proceed.
  function automatic cnt_t ready_thresh(tag_t t, cons_e c, logic data_slot);
    return full_lat(t) - eff_lat(t, c, data_slot);
  endfunction

endpackage

// File: rtl/lsb_entry.sv
module lsb_entry
  import lsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  tag_t wr_tag,
  input  cnt_t wr_load,
  output cnt_t cnt_o,
  output tag_t tag_o
);

  cnt_t cnt_q;
  tag_t tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= tag_t'('0);
    end else if (wr_en) begin
      cnt_q <= wr_load;
      tag_q <= wr_tag;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - cnt_t'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign tag_o = tag_q;

endmodule

// File: rtl/lsb_operand.sv
module lsb_operand
  import lsb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int SLOT      = 0,
  parameter int DATA_SLOT = 1,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int NE       = 2 * NUM_REGS,
  localparam int SEL_W    = $clog2(NE)
)(
  input  logic                    src_v,
  input  logic                    src_fp,
  input  logic [REG_W-1:0]        src_idx,
  input  cons_e                   cons,
  input  logic [NE-1:0][CNT_W-1:0] ent_cnt,
  input  tag_t [NE-1:0]           ent_tag,
  output logic                    rdy,
  output cnt_t                    sel_cnt
);

  localparam logic IS_DATA = (SLOT == DATA_SLOT);

  logic [SEL_W-1:0] sel;
  tag_t             sel_tag;
  cnt_t             thr;

  always_comb begin
    sel     = SEL_W'(src_idx) + (src_fp ? SEL_W'(NUM_REGS) : SEL_W'(0));
    sel_cnt = ent_cnt[sel];
    sel_tag = ent_tag[sel];
    thr     = ready_thresh(sel_tag, cons, IS_DATA);
    rdy     = !src_v || (sel_cnt <= thr);
  end

endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lsb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int N_SRC     = 3,
  parameter int DATA_SLOT = 1,
  localparam int REG_W    = $clog2(NUM_REGS)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_valid,
  input  logic [3:0]             iss_cls,
  input  logic                   iss_dbl,
  input  logic                   iss_fp,
  input  logic [REG_W-1:0]       iss_dst,
  input  logic [2:0]             cand_cls,
  input  logic [N_SRC-1:0]       cand_v,
  input  logic [N_SRC-1:0]       cand_fp,
  input  logic [N_SRC*REG_W-1:0] cand_idx,
  output logic [N_SRC-1:0]       src_rdy,
  output logic                   stall
);

  localparam int NE    = 2 * NUM_REGS;
  localparam int SEL_W = $clog2(NE);

  // Named internal events, observed by the bound checker.
  logic                     wr_fire;
  logic [SEL_W-1:0]         wr_sel;
  tag_t                     wr_tag;
  cnt_t                     wr_lat;
  cnt_t                     wr_load;
  logic [NE-1:0][CNT_W-1:0] ent_cnt;
  tag_t [NE-1:0]            ent_tag;
  logic [N_SRC-1:0][CNT_W-1:0] sel_cnt;
  cons_e                    cons;

  always_comb begin
    wr_tag.cls = prod_e'(iss_cls);
    wr_tag.dbl = iss_dbl;
    wr_lat     = full_lat(wr_tag);
    wr_load    = wr_lat - cnt_t'(1);
    wr_sel     = SEL_W'(iss_dst) + (iss_fp ? SEL_W'(NUM_REGS) : SEL_W'(0));
    wr_fire    = iss_valid && writes_dest(wr_tag.cls) && (iss_fp || (iss_dst != '0));
    cons       = cons_e'(cand_cls);
  end

  for (genvar g = 0; g < NE; g++) begin : g_ent
    if (g == 0) begin : g_zero
      // Integer register zero never holds a pending result.
      assign ent_cnt[g] = '0;
      assign ent_tag[g] = tag_t'('0);
    end else begin : g_track
      cnt_t cnt_w;
      tag_t tag_w;
      lsb_entry u_ent (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire && (wr_sel == SEL_W'(g))),
        .wr_tag  (wr_tag),
        .wr_load (wr_load),
        .cnt_o   (cnt_w),
        .tag_o   (tag_w)
      );
      assign ent_cnt[g] = cnt_w;
      assign ent_tag[g] = tag_w;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    cnt_t sc;
    lsb_operand #(
      .NUM_REGS  (NUM_REGS),
      .SLOT      (s),
      .DATA_SLOT (DATA_SLOT)
    ) u_op (
      .src_v   (cand_v[s]),
      .src_fp  (cand_fp[s]),
      .src_idx (cand_idx[s*REG_W +: REG_W]),
      .cons    (cons),
      .ent_cnt (ent_cnt),
      .ent_tag (ent_tag),
      .rdy     (src_rdy[s]),
      .sel_cnt (sc)
    );
    assign sel_cnt[s] = sc;
  end

  assign stall = !(&src_rdy);

endmodule

// File: rtl/lsb_checker.sv
module lsb_checker
  import lsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int N_SRC    = 3,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int NE      = 2 * NUM_REGS,
  localparam int SEL_W   = $clog2(NE)
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iss_valid,
  input logic [2:0]                  cand_cls,
  input logic [N_SRC-1:0]            cand_v,
  input logic [N_SRC-1:0]            cand_fp,
  input logic [N_SRC*REG_W-1:0]      cand_idx,
  input logic [N_SRC-1:0]            src_rdy,
  input logic                        stall,
  input logic                        wr_fire,
  input logic [SEL_W-1:0]            wr_sel,
  input logic [CNT_W-1:0]            wr_lat,
  input logic [NE-1:0][CNT_W-1:0]    ent_cnt,
  input logic [N_SRC-1:0][CNT_W-1:0] sel_cnt
);

  // R2 R3 R10
  load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ent_cnt[$past(wr_sel)] == cnt_t'($past(wr_lat) - cnt_t'(1)));

  // R9
  x0_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v[0] && !cand_fp[0] && (cand_idx[REG_W-1:0] == '0)) |-> src_rdy[0]);

  // R12
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v == '0) |-> !stall);

  // R6
  store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand_cls == 3'd4) && cand_v[0] && (sel_cnt[0] != '0)) |-> !src_rdy[0]);

  // R4
  plain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand_cls == 3'd0) && cand_v[0] && (sel_cnt[0] != '0)) |-> !src_rdy[0]);

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !iss_valid) |=>
      (!$stable({cand_cls, cand_v, cand_fp, cand_idx}) || !stall));

  for (genvar g = 0; g < NE; g++) begin : g_rng
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_cnt[g] < cnt_t'(MAX_LAT));
  end

endmodule

bind lat_scoreboard lsb_checker #(
  .NUM_REGS (NUM_REGS),
  .N_SRC    (N_SRC)
) u_lsb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .cand_cls  (cand_cls),
  .cand_v    (cand_v),
  .cand_fp   (cand_fp),
  .cand_idx  (cand_idx),
  .src_rdy   (src_rdy),
  .stall     (stall),
  .wr_fire   (wr_fire),
  .wr_sel    (wr_sel),
  .wr_lat    (wr_lat),
  .ent_cnt   (ent_cnt),
  .sel_cnt   (sel_cnt)
);

// File: tb/tb_lat_scoreboard.sv
module tb_lat_scoreboard;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [3:0]  iss_cls;
  logic        iss_dbl;
  logic        iss_fp;
  logic [4:0]  iss_dst;
  logic [2:0]  cand_cls;
  logic [2:0]  cand_v;
  logic [2:0]  cand_fp;
  logic [14:0] cand_idx;
  logic [2:0]  src_rdy;
  logic        stall;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  longint cyc = 0;
  longint issue_t [0:63];
  int     pcls    [0:63];
  bit     pdbl    [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_scoreboard dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .iss_dbl   (iss_dbl),
    .iss_fp    (iss_fp),
    .iss_dst   (iss_dst),
    .cand_cls  (cand_cls),
    .cand_v    (cand_v),
    .cand_fp   (cand_fp),
    .cand_idx  (cand_idx),
    .src_rdy   (src_rdy),
    .stall     (stall)
  );

  function automatic int b_lat(int p, bit d);
    case (p)
      0, 6:          return 1;
      1, 2, 9:       return 2;
      3, 4, 11, 13,
      14:            return 3;
      5:             return 16;
      10:            return d ? 7 : 5;
      12:            return d ? 56 : 27;
      default:       return 0;
    endcase
  endfunction

  function automatic int b_wait(int p, bit d, int c, bit data);
    int fwd = 0;
    bit int_fast = (p == 1) || (p == 2) || (p == 3) || (p == 4) || (p == 14);
    case (c)
      1, 2: begin
        if (int_fast) fwd = 1;
        else if (p == 11) fwd = 2;
      end
      3: if (p == 1 || p == 2) fwd = 1;
      4: if (data) begin
        if (int_fast) fwd = 1;
        else if (p == 11) fwd = 2;
      end
      5: if (p == 11 || p == 13) fwd = 2;
      default: fwd = 0;
    endcase
    return (fwd != 0) ? fwd : b_lat(p, d);
  endfunction

  function automatic bit b_ready(bit v, bit fp, int idx, int c, int slot);
    int e;
    if (!v) return 1'b1;
    if (!fp && idx == 0) return 1'b1;
    e = (fp ? 32 : 0) + idx;
    if (issue_t[e] < 0) return 1'b1;
    return (cyc - issue_t[e]) >= longint'(b_wait(pcls[e], pdbl[e], c, slot == 1));
  endfunction

  task automatic step(input bit iv, input int cls, input bit dbl, input bit fpd,
                      input int dst, input int cc, input logic [2:0] sv,
                      input logic [2:0] sfp, input logic [14:0] sidx, input string req);
    logic [3:0] exp;
    iss_valid = iv;
    iss_cls   = 4'(cls);
    iss_dbl   = dbl;
    iss_fp    = fpd;
    iss_dst   = 5'(dst);
    cand_cls  = 3'(cc);
    cand_v    = sv;
    cand_fp   = sfp;
    cand_idx  = sidx;
    #1;
    for (int s = 0; s < 3; s++)
      exp[s+1] = b_ready(sv[s], sfp[s], int'(sidx[s*5 +: 5]), cc, s);
    exp[0] = !(&exp[3:1]);
    checks++;
    if ({src_rdy, stall} !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", req, cyc, {src_rdy, stall}, exp);
    end
    @(posedge clk);
    if (iv && !(cls == 7 || cls == 8 || cls == 15) && (fpd || dst != 0)) begin
      issue_t[(fpd ? 32 : 0) + dst] = cyc;
      pcls[(fpd ? 32 : 0) + dst]    = cls;
      pdbl[(fpd ? 32 : 0) + dst]    = dbl;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic iss(input int cls, input bit dbl, input bit fpd, input int dst, input string req);
    step(1'b1, cls, dbl, fpd, dst, 0, 3'b000, 3'b000, 15'd0, req);
  endtask

  task automatic probe(input int cc, input int slot, input bit fp, input int idx, input string req);
    logic [2:0]  v = 3'b000;
    logic [2:0]  f = 3'b000;
    logic [14:0] x = 15'd0;
    v[slot] = 1'b1;
    f[slot] = fp;
    x[slot*5 +: 5] = 5'(idx);
    step(1'b0, 0, 1'b0, 1'b0, 0, cc, v, f, x, req);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin
      issue_t[i] = -1000;
      pcls[i] = 0;
      pdbl[i] = 1'b0;
    end
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_cls = '0; iss_dbl = 1'b0; iss_fp = 1'b0; iss_dst = '0;
    cand_cls = '0; cand_v = '0; cand_fp = '0; cand_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across both files
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 3'b111, 3'b000, {5'd31, 5'd9, 5'd3}, "R1");
    step(1'b0, 0, 1'b0, 1'b0, 0, 5, 3'b111, 3'b111, {5'd0, 5'd17, 5'd30}, "R1");

    // R2: divide waits full 16 cycles for a plain consumer
    iss(5, 1'b0, 1'b0, 5, "R2");
    for (int k = 1; k <= 17; k++) probe(0, 0, 1'b0, 5, "R2");

    // R4: ALU to ALU after 1; ALU to plain needs 2
    iss(1, 1'b0, 1'b0, 6, "R4");
    probe(1, 2, 1'b0, 6, "R4");
    iss(1, 1'b0, 1'b0, 6, "R2");
    probe(0, 0, 1'b0, 6, "R2");
    probe(0, 0, 1'b0, 6, "R2");

    // R6: store data slot forwards, address slot does not
    iss(3, 1'b0, 1'b0, 7, "R6");
    probe(4, 1, 1'b0, 7, "R6");
    iss(3, 1'b0, 1'b0, 7, "R6");
    for (int k = 1; k <= 3; k++) probe(4, 0, 1'b0, 7, "R6");

    // R8: FP compare into integer register, then ALU / store data
    iss(11, 1'b0, 1'b0, 8, "R8");
    probe(1, 0, 1'b0, 8, "R8");
    probe(2, 0, 1'b0, 8, "R8");
    iss(11, 1'b0, 1'b0, 8, "R8");
    probe(4, 1, 1'b0, 8, "R8");
    probe(4, 1, 1'b0, 8, "R8");

    // R7: integer-to-FP move feeding FP arithmetic
    iss(13, 1'b0, 1'b1, 3, "R7");
    probe(5, 2, 1'b1, 3, "R7");
    probe(5, 2, 1'b1, 3, "R7");

    // R3: precision-dependent FP latencies
    iss(10, 1'b1, 1'b1, 4, "R3");
    for (int k = 1; k <= 8; k++) probe(5, 0, 1'b1, 4, "R3");
    iss(10, 1'b0, 1'b1, 4, "R3");
    for (int k = 1; k <= 6; k++) probe(0, 0, 1'b1, 4, "R3");
    iss(12, 1'b1, 1'b1, 5, "R3");
    for (int k = 1; k <= 57; k++) probe(0, 1, 1'b1, 5, "R3");
    iss(12, 1'b0, 1'b1, 5, "R3");
    for (int k = 1; k <= 28; k++) probe(5, 1, 1'b1, 5, "R3");

    // R9: integer x0 ignored, FP f0 tracked
    iss(5, 1'b0, 1'b0, 0, "R9");
    probe(0, 0, 1'b0, 0, "R9");
    iss(5, 1'b0, 1'b1, 0, "R9");
    probe(0, 0, 1'b1, 0, "R9");

    // R10: newer ALU writer replaces a pending divide
    iss(5, 1'b0, 1'b0, 9, "R10");
    iss(1, 1'b0, 1'b0, 9, "R10");
    probe(1, 0, 1'b0, 9, "R10");
    probe(0, 0, 1'b0, 9, "R10");

    // R11: store / branch / reserved codes leave the register alone
    iss(7, 1'b0, 1'b0, 10, "R11");
    probe(0, 0, 1'b0, 10, "R11");
    iss(8, 1'b0, 1'b0, 10, "R11");
    probe(0, 0, 1'b0, 10, "R11");
    iss(15, 1'b0, 1'b1, 10, "R11");
    probe(0, 0, 1'b1, 10, "R11");

    // R5: short-forward-branch consumer
    iss(1, 1'b0, 1'b0, 11, "R5");
    probe(3, 0, 1'b0, 11, "R5");
    iss(3, 1'b0, 1'b0, 12, "R5");
    for (int k = 1; k <= 3; k++) probe(3, 0, 1'b0, 12, "R5");

    // R12: file separation and multi-slot combination
    iss(5, 1'b0, 1'b0, 13, "R12");
    probe(0, 0, 1'b1, 13, "R12");
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 3'b101, 3'b000, {5'd13, 5'd0, 5'd1}, "R12");
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 3'b101, 3'b000, {5'd1, 5'd13, 5'd2}, "R12");

    // Mixed random traffic on a few registers of each file (R2 R4 R10 R12)
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, int'($urandom % 16), 1'($urandom), 1'($urandom),
           int'($urandom % 4), int'($urandom % 8), 3'($urandom), 3'($urandom),
           {5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4)}, "R12");
    end

    done = 1'b1;
    finish_run();
  end

endmodule